// File: doc/BRIEF.md
# Static RAM self-test controller

This block exercises one asynchronous static RAM through a fixed series of tests and reports the result as an 8-bit status byte. Each bit of that byte drives one indicator lamp. The RAM data width is a parameter: 4 bits for a 1k x 4 device and 8 bits for a 2k x 8 device. The block drives the RAM address, data and write-enable pins directly. It times every access with a fixed number of clocks. It samples read data on the last clock of a read access.

A pulse on `start` runs the tests in a fixed order, and the run stops at the first mismatch:

1. A data sweep over every data code.
2. Address-as-data passes, one for each address slice, highest slice first.
3. Two gapless fills with alternating bit patterns, each followed by a readback.

When a run ends, `done` rises and the status byte holds the outcome. After a failure, the failing address, the value written and the value read are also available. With `hold_en` high, the block keeps rewriting and rereading the failing location. This lets a fault be traced in the circuit.

Top module: `sram_selftest`

## Requirements
- R1: While `rst` is high and after it is released, `done`, `busy` and `ram_we` are 0 and `status` is 8'h00.
- R2: A `start` pulse while the block is idle or done begins a run. A `start` while the block is busy has no effect. The run first writes value v to every location, reads every location back, then moves on to v+1. The sweep covers v = 0 up to the all-ones code, so with 64 locations and 4 data bits the first 1024 writes are 64 copies each of 0, 1, ..., 15.
- R3: The address test follows. Each pass writes every location with the bits [s*DATA_W+DATA_W-1 : s*DATA_W] of its own address, then reads all locations back. Passes run from the highest slice s down to slice 0.
- R4: The fill test runs two passes, p = 0 then p = 1. Pass p writes 1010... (4'hA for 4 bits) where addr[0]^p is 0 and the inverse pattern elsewhere, so consecutive writes are bitwise inverses. Each pass reads all locations back afterwards.
- R5: At the first read mismatch the run stops. `fail_addr`, `fail_wr` (the expected value) and `fail_rd` (the value read) are captured. While `done` stays high, `status` does not change.
- R6: The status codes are:
  - 8'h03 when every test passes.
  - 8'hE0 for a data-sweep error.
  - 8'hCC for a fill-test error.
  - For an address-slice error, bits 7 and 6 plus one slice bit. With 4-bit data, slice s sets bit s+2. With 8-bit data, slice s sets bit s+3.
- R7: `busy` is high during a run and `done` is high once it ends; the two are never high together.
- R8: Each access lasts ACC_CLKS clocks with no idle clock between accesses. The address and data are steady on the clock before `ram_we` rises and on the clock after it falls. Read data is sampled on the last clock of the access.
- R9: If `hold_en` is high at a failure, the block repeatedly writes `fail_wr` to `fail_addr` and reads it back. After each retry it updates `retry_ok` (1 when the read matches) and `fail_rd`. It stops writing once `hold_en` is low at the end of a retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle or done |
| hold_en | input | 1 | Retry the failing location instead of stopping |
| ram_addr | output | ADDR_W | RAM address |
| ram_we | output | 1 | RAM write enable, active high |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data |
| busy | output | 1 | Test run in progress |
| done | output | 1 | Run finished (also high while retrying) |
| status | output | 8 | Lamp status code |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_wr | output | DATA_W | Value written there |
| fail_rd | output | DATA_W | Value read back (refreshed on each retry) |
| retry_ok | output | 1 | Result of the latest retry |

## Verification
The assertions assume that `start` is only meaningful while the block is idle or done. They also assume the RAM model returns the stored word combinationally from `ram_addr`, and that `hold_en` changes only between runs or during a retry loop.

The bench runs with ACC_CLKS=3, so each write raises `ram_we` for exactly one clock. It places faults only in its RAM model:
- a stuck data bit;
- a tied address line;
- a write that is dropped when it inverts the previous write.

The bench drives `start` and `hold_en` one time unit after a rising edge. It issues a single `start` while the block is busy, to confirm that the pulse is ignored.

// File: rtl/sramt_pkg.sv
package sramt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DATA_W,
        ST_DATA_R,
        ST_ADDR_W,
        ST_ADDR_R,
        ST_FAST_W,
        ST_FAST_R,
        ST_HOLD_W,
        ST_HOLD_R,
        ST_DONE
    } st_e;

    localparam logic [7:0] STAT_PASS = 8'h03;
    localparam logic [7:0] STAT_DATA = 8'hE0;
    localparam logic [7:0] STAT_FAST = 8'hCC;
    localparam logic [7:0] STAT_FAIL = 8'hC0;

    // lamp code for an address-slice failure
    function automatic logic [7:0] slice_code(input int unsigned s, input int unsigned dw);
        int unsigned bitpos;
        bitpos = s + ((dw == 8) ? 3 : 2);
        return STAT_FAIL | (8'h01 << bitpos);
    endfunction

endpackage

// File: rtl/sramt_strobe.sv
module sramt_strobe #(
    parameter int ACC_CLKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic wr,
    output logic we,
    output logic step
);
    localparam int PW = (ACC_CLKS > 1) ? $clog2(ACC_CLKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(ACC_CLKS - 1);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !run) phase <= '0;
        else if (phase == LAST) phase <= '0;
        else phase <= phase + 1'b1;
    end

    assign step = run && (phase == LAST);
    assign we   = run && wr && (phase != '0) && (phase != LAST);
endmodule

// File: rtl/sramt_opgen.sv
module sramt_opgen
    import sramt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4
) (
    input  st_e                                      st,
    input  logic [ADDR_W-1:0]                        addr,
    input  logic [DATA_W-1:0]                        val,
    input  logic [((ADDR_W+DATA_W-1)/DATA_W > 1 ? $clog2((ADDR_W+DATA_W-1)/DATA_W) : 1)-1:0] slice,
    input  logic                                     fpass,
    input  logic [ADDR_W-1:0]                        fail_addr,
    input  logic [DATA_W-1:0]                        fail_wr,
    output logic [ADDR_W-1:0]                        op_addr,
    output logic [DATA_W-1:0]                        op_data
);
    localparam logic [DATA_W-1:0] ALT = {(DATA_W/2){2'b10}};

    logic [ADDR_W-1:0] shifted;

    always_comb begin
        shifted = addr >> (DATA_W * int'(slice));
        op_addr = addr;
        case (st)
            ST_DATA_W, ST_DATA_R: op_data = val;
            ST_ADDR_W, ST_ADDR_R: op_data = shifted[DATA_W-1:0];
            ST_FAST_W, ST_FAST_R: op_data = (addr[0] ^ fpass) ? ~ALT : ALT;
            ST_HOLD_W, ST_HOLD_R: begin
                op_addr = fail_addr;
                op_data = fail_wr;
            end
            default: op_data = '0;
        endcase
    end
endmodule

// File: rtl/sramt_seq.sv
module sramt_seq
    import sramt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4,
    localparam int NS  = (ADDR_W + DATA_W - 1) / DATA_W,
    localparam int SLW = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              hold_en,
    input  logic              step,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] expect_d,
    output st_e               st,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] val,
    output logic [SLW-1:0]    slice,
    output logic              fpass,
    output logic              run,
    output logic              op_wr,
    output logic              busy,
    output logic              done,
    output logic [7:0]        status,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_wr,
    output logic [DATA_W-1:0] fail_rd,
    output logic              retry_ok
);
    localparam logic [DATA_W-1:0] VMAX      = '1;
    localparam logic [ADDR_W-1:0] AMAX      = '1;
    localparam logic [SLW-1:0]    SLICE_TOP = SLW'(NS - 1);

    logic       at_last, mism, checking, holding;
    logic [7:0] fcode;

    assign at_last  = (addr == AMAX);
    assign mism     = (rdata != expect_d);
    assign checking = (st == ST_DATA_R) || (st == ST_ADDR_R) || (st == ST_FAST_R);
    assign holding  = (st == ST_HOLD_W) || (st == ST_HOLD_R);
    assign run      = (st != ST_IDLE) && (st != ST_DONE);
    assign busy     = run && !holding;
    assign done     = (st == ST_DONE) || holding;
    assign op_wr    = (st == ST_DATA_W) || (st == ST_ADDR_W) ||
                      (st == ST_FAST_W) || (st == ST_HOLD_W);

    always_comb begin
        case (st)
            ST_ADDR_R: fcode = slice_code(int'(slice), DATA_W);
            ST_FAST_R: fcode = STAT_FAST;
            default:   fcode = STAT_DATA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            addr      <= '0;
            val       <= '0;
            slice     <= SLICE_TOP;
            fpass     <= 1'b0;
            status    <= '0;
            fail_addr <= '0;
            fail_wr   <= '0;
            fail_rd   <= '0;
            retry_ok  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        st       <= ST_DATA_W;
                        addr     <= '0;
                        val      <= '0;
                        slice    <= SLICE_TOP;
                        fpass    <= 1'b0;
                        status   <= '0;
                        retry_ok <= 1'b0;
                    end
                end
                default: begin
                    if (step) begin
                        if (checking && mism) begin
                            status    <= fcode;
                            fail_addr <= addr;
                            fail_wr   <= expect_d;
                            fail_rd   <= rdata;
                            addr      <= '0;
                            st        <= hold_en ? ST_HOLD_W : ST_DONE;
                        end else begin
                            addr <= at_last ? '0 : addr + 1'b1;
                            case (st)
                                ST_DATA_W: if (at_last) st <= ST_DATA_R;
                                ST_DATA_R: if (at_last) begin
                                    if (val == VMAX) st <= ST_ADDR_W;
                                    else begin
                                        val <= val + 1'b1;
                                        st  <= ST_DATA_W;
                                    end
                                end
                                ST_ADDR_W: if (at_last) st <= ST_ADDR_R;
                                ST_ADDR_R: if (at_last) begin
                                    if (slice == '0) st <= ST_FAST_W;
                                    else begin
                                        slice <= slice - 1'b1;
                                        st    <= ST_ADDR_W;
                                    end
                                end
                                ST_FAST_W: if (at_last) st <= ST_FAST_R;
                                ST_FAST_R: if (at_last) begin
                                    if (fpass) begin
                                        st     <= ST_DONE;
                                        status <= STAT_PASS;
                                    end else begin
                                        fpass <= 1'b1;
                                        st    <= ST_FAST_W;
                                    end
                                end
                                ST_HOLD_W: st <= ST_HOLD_R;
                                ST_HOLD_R: begin
                                    retry_ok <= !mism;
                                    fail_rd  <= rdata;
                                    st       <= hold_en ? ST_HOLD_W : ST_DONE;
                                end
                                default: st <= ST_IDLE;
                            endcase
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sram_selftest.sv
module sram_selftest
    import sramt_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 4,
    parameter int ACC_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              hold_en,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              busy,
    output logic              done,
    output logic [7:0]        status,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_wr,
    output logic [DATA_W-1:0] fail_rd,
    output logic              retry_ok
);
    localparam int NS  = (ADDR_W + DATA_W - 1) / DATA_W;
    localparam int SLW = (NS > 1) ? $clog2(NS) : 1;

    st_e               st;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] val;
    logic [SLW-1:0]    slice;
    logic              fpass, run, op_wr, step;
    logic [DATA_W-1:0] op_data;

    sramt_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .hold_en(hold_en), .step(step),
        .rdata(ram_rdata), .expect_d(op_data), .st(st), .addr(addr), .val(val),
        .slice(slice), .fpass(fpass), .run(run), .op_wr(op_wr), .busy(busy),
        .done(done), .status(status), .fail_addr(fail_addr), .fail_wr(fail_wr),
        .fail_rd(fail_rd), .retry_ok(retry_ok)
    );

    sramt_opgen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_opgen (
        .st(st), .addr(addr), .val(val), .slice(slice), .fpass(fpass),
        .fail_addr(fail_addr), .fail_wr(fail_wr),
        .op_addr(ram_addr), .op_data(op_data)
    );

    sramt_strobe #(.ACC_CLKS(ACC_CLKS)) u_strobe (
        .clk(clk), .rst(rst), .run(run), .wr(op_wr), .we(ram_we), .step(step)
    );

    assign ram_wdata = op_data;
endmodule

// File: rtl/sramt_checker.sv
module sramt_checker #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_we,
    input logic [DATA_W-1:0] ram_wdata,
    input logic              busy,
    input logic              done,
    input logic [7:0]        status,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [DATA_W-1:0] fail_wr
);
    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_status_form_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (status == 8'h03) ||
                 (status[7:6] == 2'b11 && status[1:0] == 2'b00 &&
                  ($countones(status[5:2]) == 1 || status[5:2] == 4'b0011)));

    assert_status_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> $stable(status));

    assert_no_we_after_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (done && status == 8'h03) |-> !ram_we);

    assert_we_owner_R9: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (busy || (done && status[7])));

    assert_we_setup_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we) |-> ($stable(ram_addr) && $stable(ram_wdata)));

    assert_we_release_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_we) |-> ($stable(ram_addr) && $stable(ram_wdata)));

    assert_hold_target_R9: assert property (@(posedge clk) disable iff (rst)
        (done && ram_we) |-> (ram_addr == fail_addr && ram_wdata == fail_wr));
endmodule

bind sram_selftest sramt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .busy(busy), .done(done), .status(status),
    .fail_addr(fail_addr), .fail_wr(fail_wr)
);

// File: tb/sram_selftest_tb.sv
module sram_selftest_tb;
    localparam int AW = 6;
    localparam int DW = 4;
    localparam int ACC = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          hold_en = 1'b0;
    logic [AW-1:0] ram_addr, fail_addr;
    logic          ram_we, busy, done, retry_ok;
    logic [DW-1:0] ram_wdata, ram_rdata, fail_wr, fail_rd;
    logic [7:0]    status;

    always #5 clk = ~clk;

    sram_selftest #(.ADDR_W(AW), .DATA_W(DW), .ACC_CLKS(ACC)) u_dut (
        .clk(clk), .rst(rst), .start(start), .hold_en(hold_en),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .busy(busy), .done(done), .status(status),
        .fail_addr(fail_addr), .fail_wr(fail_wr), .fail_rd(fail_rd),
        .retry_ok(retry_ok)
    );

    // ---------------- RAM model with injectable faults ----------------
    logic [DW-1:0] mem [1<<AW];
    logic [AW-1:0] alias_mask = '0;
    logic          stuck_on = 1'b0;
    logic          drop_on = 1'b0;
    logic [DW-1:0] prev_w = '0;

    function automatic logic [AW-1:0] phys(input logic [AW-1:0] a);
        return a & ~alias_mask;
    endfunction

    initial for (int i = 0; i < (1 << AW); i++) mem[i] = '0;

    always @(posedge clk) begin
        if (ram_we) begin
            if (!(drop_on && phys(ram_addr) == 6'h21 && ram_wdata == ~prev_w))
                mem[phys(ram_addr)] <= ram_wdata;
            prev_w <= ram_wdata;
        end
    end

    always_comb begin
        ram_rdata = mem[phys(ram_addr)];
        if (stuck_on && ram_addr == 6'h05) ram_rdata[1] = 1'b0;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [7:0]    st;
        logic [AW-1:0] a;
        logic [DW-1:0] w;
        logic [DW-1:0] r;
        int            nw;
        string         req;
    } exp_t;

    exp_t          expq[$];
    logic [DW-1:0] wlog[$];
    int            wcyc[$];
    int tests = 0, fails = 0, processed = 0, wcount = 0, cyc = 0;
    logic we_prev = 1'b0, done_prev = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (start && !busy) begin
                wcount = 0;
                wlog.delete();
                wcyc.delete();
            end
            if (ram_we && !we_prev) begin
                wcount++;
                wlog.push_back(ram_wdata);
                wcyc.push_back(cyc);
            end
            if (done && !done_prev) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R7", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(status == e.st, "R6", {e.req, " status"}, int'(status), int'(e.st));
                    if (e.st != 8'h03) begin
                        chk(fail_addr == e.a, "R5", {e.req, " fail_addr"}, int'(fail_addr), int'(e.a));
                        chk(fail_wr == e.w, "R5", {e.req, " fail_wr"}, int'(fail_wr), int'(e.w));
                        chk(fail_rd == e.r, "R5", {e.req, " fail_rd"}, int'(fail_rd), int'(e.r));
                    end
                    if (e.nw >= 0)
                        chk(wcount == e.nw, "R5", {e.req, " write count"}, wcount, e.nw);
                end
                processed++;
            end
        end
        we_prev   = ram_we;
        done_prev = done;
    end

    // ---------------- driver ----------------
    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic run_case(input exp_t e, input bit hold, input bit poke_busy);
        int target;
        target = processed + 1;
        expq.push_back(e);
        hold_en = hold;
        pulse_start();
        if (poke_busy) begin
            repeat (100) @(posedge clk);
            #1 chk(busy == 1'b1 && done == 1'b0, "R7", "busy during run", int'(busy), 1);
            pulse_start();   // R2: ignored while busy
        end
        wait (processed == target);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R7", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        exp_t e;
        int bad;
        int wc;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(done == 0 && busy == 0 && ram_we == 0 && status == 8'h00, "R1",
            "reset state", int'({done, busy, ram_we}), 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(done == 0 && busy == 0 && status == 8'h00, "R1", "after release",
            int'(status), 0);

        // Good RAM, extra start while busy (R2)
        e = '{st: 8'h03, a: '0, w: '0, r: '0, nw: 1280, req: "R2 good"};
        run_case(e, 1'b0, 1'b1);
        chk(done == 1'b1 && busy == 1'b0, "R7", "done after pass", int'(done), 1);
        chk(wlog[0] == 4'h0 && wlog[63] == 4'h0 && wlog[64] == 4'h1 && wlog[960] == 4'hF,
            "R2", "data sweep order", int'(wlog[960]), 15);
        // R3: high slice first, then low slice
        chk(wlog[1024 + 16] == 4'h1, "R3", "high slice write", int'(wlog[1040]), 1);
        chk(wlog[1088 + 16] == 4'h0 && wlog[1088 + 5] == 4'h5, "R3", "low slice write",
            int'(wlog[1093]), 5);
        // R4: alternating fill
        chk(wlog[1152] == 4'hA && wlog[1216] == 4'h5, "R4", "fill start patterns",
            int'(wlog[1152]), 10);
        bad = 0;
        for (int i = 1153; i < 1280; i++)
            if (i != 1216 && wlog[i] != ~wlog[i-1]) bad++;
        chk(bad == 0, "R4", "consecutive fill writes inverted", bad, 0);
        // R8: gapless accesses of ACC clocks
        bad = 0;
        for (int i = 1153; i < 1216; i++)
            if (wcyc[i] - wcyc[i-1] != ACC) bad++;
        chk(bad == 0, "R8", "write spacing", bad, 0);

        // Stuck data bit: data error at value 2, address 5
        stuck_on = 1'b1;
        e = '{st: 8'hE0, a: 6'h05, w: 4'h2, r: 4'h0, nw: 192, req: "R5 data fault"};
        run_case(e, 1'b0, 1'b0);
        stuck_on = 1'b0;

        // Tied address line A4: high slice fails
        alias_mask = 6'h10;
        e = '{st: 8'hC8, a: 6'h00, w: 4'h0, r: 4'h1, nw: 1088, req: "R3 high slice"};
        run_case(e, 1'b0, 1'b0);

        // Tied address line A1: low slice fails
        alias_mask = 6'h02;
        e = '{st: 8'hC4, a: 6'h00, w: 4'h0, r: 4'h2, nw: 1152, req: "R3 low slice"};
        run_case(e, 1'b0, 1'b0);
        alias_mask = '0;

        // Dropped inverting write at 0x21: fill test fails
        drop_on = 1'b1;
        e = '{st: 8'hCC, a: 6'h21, w: 4'h5, r: 4'h1, nw: 1216, req: "R4 fill fault"};
        run_case(e, 1'b0, 1'b0);
        drop_on = 1'b0;

        // Hold on error (R9)
        stuck_on = 1'b1;
        e = '{st: 8'hE0, a: 6'h05, w: 4'h2, r: 4'h0, nw: -1, req: "R9 hold"};
        run_case(e, 1'b1, 1'b0);
        repeat (20) @(posedge clk);
        #1 chk(retry_ok == 1'b0 && fail_rd == 4'h0, "R9", "retry while faulty",
               int'(fail_rd), 0);
        stuck_on = 1'b0;
        repeat (20) @(posedge clk);
        #1 chk(retry_ok == 1'b1 && fail_rd == 4'h2, "R9", "retry after repair",
               int'(fail_rd), 2);
        hold_en = 1'b0;
        repeat (20) @(posedge clk);
        wc = wcount;
        repeat (30) @(posedge clk);
        #1 chk(wcount == wc && done == 1'b1 && status == 8'hE0, "R9", "retry loop left",
               wcount - wc, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule